// File: doc/BRIEF.md
# OFDM Frame Airtime Calculator

This block works out how long a frame occupies the medium. It takes a frame length in bytes, a bit rate counted in steps of 100 kbit/s and a channel bandwidth mode, and produces a duration in microseconds. The duration is the interframe gap, plus the preamble, plus a whole number of OFDM symbols. The payload is first padded by a fixed header-and-tail overhead of 22 bits. The symbol count is then rounded up, so a partly used symbol still costs its full time.

A request is made by pulsing `start` while the unit is idle. The unit copies the inputs and divides the scaled bit count by the bits carried per symbol, using a serial restoring divider that settles one quotient bit per clock. It then pulses `done` for one cycle together with the result. The result and error flag then hold until the next completion.

Four bandwidth modes change the timing set:
- Full rate: 4 µs symbol, 16 µs preamble, 16 µs gap.
- Turbo: 4 µs symbol, 8 µs preamble, 8 µs gap.
- Half rate: 8 µs symbol, 32 µs preamble, 32 µs gap.
- Quarter rate: 16 µs symbol, 64 µs preamble, 64 µs gap.

Top module: `ofdm_airtime_calc`

## Requirements
- R1: After reset, busy, done and err are 0 and duration is 0.
- R2: In full-rate mode (bw_mode = 0), duration = 16 + 16 + 4·N. Here N = ceil((22 + 8·len)·10 / (rate·4)).
- R3: In turbo mode (bw_mode = 1), duration = 8 + 8 + 4·N. Here N = ceil((22 + 8·len)·10 / (rate·4)).
- R4: In half-rate mode (bw_mode = 2), duration = 32 + 32 + 8·N. Here N = ceil((22 + 8·len)·10 / (rate·8)).
- R5: In quarter-rate mode (bw_mode = 3), duration = 64 + 64 + 16·N. Here N = ceil((22 + 8·len)·10 / (rate·16)).
- R6: The symbol count rounds up only when the division leaves a remainder. An exact quotient adds no extra symbol.
- R7: A request with rate = 0 raises done with err = 1 and duration = 0, at the first clock edge after the start edge.
- R8: An accepted request with a nonzero rate raises busy at the accepting edge. With the default widths (19 quotient bits plus one finishing cycle), done is a one-cycle pulse 20 clock edges after the accepting edge, and busy is 0 while done is 1.
- R9: Start is ignored while busy is 1. Input changes during that time do not alter the result of the request in flight.
- R10: A duration that exceeds 65535 is reported as 65535.
- R11: Duration and err keep their values between completions, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, sampled while idle |
| len_bytes | input | 12 | Frame length in bytes |
| rate_100k | input | 10 | Bit rate in units of 100 kbit/s |
| bw_mode | input | 2 | 0 full, 1 turbo, 2 half, 3 quarter |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request had a zero rate |
| duration | output | 16 | Airtime in µs, saturated |

## Verification
The hardest situation to reach from the ports is a request arriving while the divider is mid-run. The bench holds start high for several cycles after acceptance and changes all three operands during that time, so that any leakage shows up in the result. A second hard case is a new request landing in the very cycle that done is high. The bench issues a zero-rate request on that cycle, which checks that the unit is idle again at once. Saturation is reached with the longest frame at the lowest rate in quarter-rate mode. The exact-division case uses operands whose bit count divides evenly into the bits per symbol.

// File: rtl/airtime_pkg.sv
package airtime_pkg;

  typedef enum logic [1:0] {
    BW_FULL    = 2'd0,
    BW_TURBO   = 2'd1,
    BW_HALF    = 2'd2,
    BW_QUARTER = 2'd3
  } bw_mode_e;

  typedef struct packed {
    logic [7:0] sym_us;
    logic [7:0] pre_us;
    logic [7:0] sifs_us;
  } ifs_set_t;

  localparam int unsigned HDR_BITS     = 22;
  localparam int unsigned BASE_SYM     = 4;
  localparam int unsigned BASE_PRE     = 16;
  localparam int unsigned BASE_SIFS    = 16;
  localparam int unsigned TURBO_PRE    = 8;
  localparam int unsigned TURBO_SIFS   = 8;
  localparam int unsigned HALF_SIFS    = 32;
  localparam int unsigned QUARTER_SIFS = 64;

  function automatic logic [7:0] sym_time_of(bw_mode_e m);
    case (m)
      BW_HALF:    return 8'(BASE_SYM * 2);
      BW_QUARTER: return 8'(BASE_SYM * 4);
      default:    return 8'(BASE_SYM);
    endcase
  endfunction

  function automatic ifs_set_t timing_for(bw_mode_e m);
    ifs_set_t t;
    t.sym_us = sym_time_of(m);
    case (m)
      BW_TURBO:   begin t.pre_us = 8'(TURBO_PRE);    t.sifs_us = 8'(TURBO_SIFS);   end
      BW_HALF:    begin t.pre_us = 8'(BASE_PRE * 2); t.sifs_us = 8'(HALF_SIFS);    end
      BW_QUARTER: begin t.pre_us = 8'(BASE_PRE * 4); t.sifs_us = 8'(QUARTER_SIFS); end
      default:    begin t.pre_us = 8'(BASE_PRE);     t.sifs_us = 8'(BASE_SIFS);    end
    endcase
    return t;
  endfunction

  // Scaled numerator: (header bits + 8 * bytes) * 10
  function automatic logic [31:0] bits_x10(logic [31:0] nbytes);
    return (32'(HDR_BITS) + (nbytes << 3)) * 32'd10;
  endfunction

  // Unsaturated airtime for a symbol count
  function automatic logic [31:0] raw_airtime(ifs_set_t t, logic [31:0] nsym);
    return 32'(t.sifs_us) + 32'(t.pre_us) + 32'(t.sym_us) * nsym;
  endfunction

endpackage

// File: rtl/airtime_mode_lut.sv
module airtime_mode_lut
  import airtime_pkg::*;
(
  input  bw_mode_e mode_i,
  output ifs_set_t set_o
);
  assign set_o = timing_for(mode_i);
endmodule

// File: rtl/serial_restoring_div.sv
module serial_restoring_div #(
  parameter int NUM_W = 19,
  parameter int DEN_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [NUM_W-1:0] dividend_i,
  input  logic [DEN_W-1:0] divisor_i,
  output logic             step_last_o,
  output logic [NUM_W-1:0] quot_o,
  output logic [DEN_W-1:0] rem_o,
  output logic [DEN_W-1:0] den_o
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] dvd_q, quo_q;
  logic [DEN_W-1:0] rem_q, dsr_q;
  logic [CNT_W-1:0] cnt_q;

  logic [DEN_W:0] trial, diff;
  logic           take;

  assign trial = {rem_q, dvd_q[NUM_W-1]};
  assign take  = trial >= {1'b0, dsr_q};
  assign diff  = trial - {1'b0, dsr_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dvd_q <= '0;
      quo_q <= '0;
      rem_q <= '0;
      dsr_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      dvd_q <= dividend_i;
      quo_q <= '0;
      rem_q <= '0;
      dsr_q <= divisor_i;
      cnt_q <= CNT_W'(NUM_W);
    end else if (cnt_q != '0) begin
      dvd_q <= dvd_q << 1;
      quo_q <= {quo_q[NUM_W-2:0], take};
      rem_q <= take ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign step_last_o = (cnt_q == CNT_W'(1));
  assign quot_o      = quo_q;
  assign rem_o       = rem_q;
  assign den_o       = dsr_q;
endmodule

// File: rtl/ofdm_airtime_calc.sv
module ofdm_airtime_calc
  import airtime_pkg::*;
#(
  parameter int LEN_W  = 12,
  parameter int RATE_W = 10,
  parameter int DUR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  len_bytes,
  input  logic [RATE_W-1:0] rate_100k,
  input  logic [1:0]        bw_mode,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DUR_W-1:0]  duration
);
  localparam int          NUM_MAX = (HDR_BITS + 8 * ((1 << LEN_W) - 1)) * 10;
  localparam int          NUM_W   = $clog2(NUM_MAX + 1);
  localparam int          DEN_W   = RATE_W + 8;
  localparam logic [31:0] DUR_MAX = (32'd1 << DUR_W) - 32'd1;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} st_e;

  st_e        state_q;
  bw_mode_e   mode_q;
  ifs_set_t   tim_q;

  // Named internal events
  logic accept_w, zero_rate_w, load_w, div_last_w;

  logic [NUM_W-1:0] dividend_w;
  logic [DEN_W-1:0] divisor_w;
  logic [NUM_W-1:0] div_quot;
  logic [DEN_W-1:0] div_rem, div_den;
  logic [31:0]      nsym_w, total_w;
  logic [DUR_W-1:0] dur_next_w;

  assign accept_w    = start && (state_q == ST_IDLE);
  assign zero_rate_w = (rate_100k == '0);
  assign load_w      = accept_w && !zero_rate_w;
  assign dividend_w  = NUM_W'(bits_x10(32'(len_bytes)));
  assign divisor_w   = DEN_W'(32'(rate_100k) * 32'(sym_time_of(bw_mode_e'(bw_mode))));

  airtime_mode_lut u_lut (
    .mode_i (mode_q),
    .set_o  (tim_q)
  );

  serial_restoring_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_w),
    .dividend_i  (dividend_w),
    .divisor_i   (divisor_w),
    .step_last_o (div_last_w),
    .quot_o      (div_quot),
    .rem_o       (div_rem),
    .den_o       (div_den)
  );

  // Ceiling: one more symbol when a remainder is left
  assign nsym_w     = 32'(div_quot) + 32'(div_rem != '0);
  assign total_w    = raw_airtime(tim_q, nsym_w);
  assign dur_next_w = (total_w > DUR_MAX) ? '1 : DUR_W'(total_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      mode_q   <= BW_FULL;
      done     <= 1'b0;
      err      <= 1'b0;
      duration <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept_w) begin
            if (zero_rate_w) begin
              done     <= 1'b1;
              err      <= 1'b1;
              duration <= '0;
            end else begin
              mode_q  <= bw_mode_e'(bw_mode);
              state_q <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (div_last_w) state_q <= ST_FIN;
        end
        default: begin
          state_q  <= ST_IDLE;
          done     <= 1'b1;
          err      <= 1'b0;
          duration <= dur_next_w;
        end
      endcase
    end
  end

  assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/ofdm_airtime_calc_chk.sv
module ofdm_airtime_calc_chk #(
  parameter int RATE_W = 10,
  parameter int DEN_W  = 18,
  parameter int DUR_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [RATE_W-1:0] rate_100k,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [DUR_W-1:0]  duration,
  input logic [1:0]        mode_q,
  input logic [DEN_W-1:0]  div_rem,
  input logic [DEN_W-1:0]  div_den
);
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && rate_100k != '0) |=> busy); // R8

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (duration == '0)); // R7

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(duration) && $stable(err))); // R11

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mode_q)); // R9

  AST_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (div_rem < div_den)); // R6
endmodule

bind ofdm_airtime_calc ofdm_airtime_calc_chk #(
  .RATE_W(RATE_W), .DEN_W(DEN_W), .DUR_W(DUR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .rate_100k (rate_100k),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .duration  (duration),
  .mode_q    (mode_q),
  .div_rem   (div_rem),
  .div_den   (div_den)
);

// File: tb/ofdm_airtime_calc_test.sv
module ofdm_airtime_calc_test;
  localparam int LAT = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] len_bytes = '0;
  logic [9:0]  rate_100k = '0;
  logic [1:0]  bw_mode = '0;
  logic        busy, done, err;
  logic [15:0] duration;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  ofdm_airtime_calc uut (
    .clk(clk), .rst_n(rst_n), .start(start), .len_bytes(len_bytes),
    .rate_100k(rate_100k), .bw_mode(bw_mode), .busy(busy), .done(done),
    .err(err), .duration(duration)
  );

  function automatic int ref_dur(int nbytes, int rate, int mode);
    int sym, pre, gap, num, den, n, d;
    case (mode)
      1: begin sym = 4;  pre = 8;  gap = 8;  end
      2: begin sym = 8;  pre = 32; gap = 32; end
      3: begin sym = 16; pre = 64; gap = 64; end
      default: begin sym = 4; pre = 16; gap = 16; end
    endcase
    num = (22 + 8 * nbytes) * 10;
    den = rate * sym;
    n = (num + den - 1) / den;
    d = gap + pre + sym * n;
    return (d > 65535) ? 65535 : d;
  endfunction

  task automatic check(bit ok, string req, int act, int expv, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Behavioural reference, advanced on every rising edge
  int m_left = 0;
  int m_pend = 0;
  int m_done = 0, m_err = 0, m_dur = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_left = 0; m_done = 0; m_err = 0; m_dur = 0;
    end else begin
      m_done = 0;
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) begin m_done = 1; m_err = 0; m_dur = m_pend; end
      end else if (start) begin
        if (rate_100k == 0) begin m_done = 1; m_err = 1; m_dur = 0; end
        else begin
          m_pend = ref_dur(int'(len_bytes), int'(rate_100k), int'(bw_mode));
          m_left = LAT;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(busy == (m_left > 0), "R8", busy, m_left > 0, "busy vs model");
      check(done == m_done, "R8", done, m_done, "done vs model");
      check(err == m_err, "R7", err, m_err, "err vs model");
      check(int'(duration) == m_dur, cur_req, duration, m_dur, "duration vs model");
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Issue one request and return cycles from the accepting edge to done
  task automatic run_req(int nbytes, int rate, int mode, output int cyc);
    @(negedge clk);
    len_bytes = 12'(nbytes); rate_100k = 10'(rate); bw_mode = 2'(mode);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done) begin @(negedge clk); cyc++; end
  endtask

  task automatic expect_result(string req, int nbytes, int rate, int mode, int expv);
    int cyc;
    cur_req = req;
    run_req(nbytes, rate, mode, cyc);
    check(int'(duration) == expv, req, duration, expv, "duration literal");
    check(int'(duration) == ref_dur(nbytes, rate, mode), req, duration,
          ref_dur(nbytes, rate, mode), "duration formula");
    check(err == 1'b0, req, err, 0, "err clear");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int cyc;
    int held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 0 && done == 0 && err == 0, "R1", {busy, done, err}, 0, "flags in reset");
    check(duration == 0, "R1", duration, 0, "duration in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && duration == 0, "R1", duration, 0, "after reset release");

    // R2 full rate
    expect_result("R2", 10, 60, 0, 52);
    expect_result("R2", 1500, 540, 0, 256);
    // R3 turbo
    expect_result("R3", 10, 60, 1, 36);
    // R4 half rate
    expect_result("R4", 10, 60, 2, 88);
    // R5 quarter rate
    expect_result("R5", 10, 60, 3, 160);
    // R6 exact division: no extra symbol
    expect_result("R6", 10, 5, 0, 236);
    expect_result("R6", 0, 1, 0, 252);
    // R10 saturation
    expect_result("R10", 4095, 1, 3, 65535);

    // R8 latency and pulse width
    cur_req = "R8";
    run_req(100, 120, 0, cyc);
    check(cyc == LAT, "R8", cyc, LAT, "latency");
    @(negedge clk);
    check(done == 0, "R8", done, 0, "done single cycle");

    // R7 zero rate
    cur_req = "R7";
    run_req(50, 0, 2, cyc);
    check(cyc == 0, "R7", cyc, 0, "zero-rate latency");
    check(err == 1 && duration == 0, "R7", duration, 0, "zero-rate result");

    // R9 start held high while busy with changing inputs
    cur_req = "R9";
    @(negedge clk);
    len_bytes = 12'd10; rate_100k = 10'd60; bw_mode = 2'd0; start = 1'b1;
    @(negedge clk);
    len_bytes = 12'd4095; rate_100k = 10'd1; bw_mode = 2'd3;
    for (int i = 0; i < 4; i++) @(negedge clk);
    start = 1'b0;
    held = 0;
    while (!done) begin @(negedge clk); held++; end
    check(duration == 16'd52, "R9", duration, 52, "result of held start");

    // Back-to-back: zero-rate request on the done cycle
    len_bytes = 12'd20; rate_100k = 10'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1 && err == 1, "R7", {done, err}, 3, "request on done cycle");

    // R11 hold: produce a value, then wiggle inputs without start
    cur_req = "R11";
    run_req(300, 240, 2, cyc);
    len_bytes = 12'd7; rate_100k = 10'd3; bw_mode = 2'd1;
    for (int i = 0; i < 6; i++) @(negedge clk);
    check(int'(duration) == ref_dur(300, 240, 2), "R11", duration,
          ref_dur(300, 240, 2), "held duration");
    check(err == 0, "R11", err, 0, "held err");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule